// File: doc/BRIEF.md
# Key-Addressed Match-Vector CAM with Slot Allocator

This block is a small exact-match table built from ordinary storage. The lookup key is used directly as the address of a memory whose words are match vectors. Each vector has one bit per table slot, and a set bit says that the slot holds this key. A separate value store, indexed by slot number, holds the data for each entry. A free-slot bitmap, in which 1 marks a slot as available, feeds a lowest-index priority encoder that chooses the slot for each new insert.

Three operations are supported. An insert sets one bit in the key's vector and writes the value. A query priority-encodes the key's vector and returns the value of the lowest matching slot. A delete clears that slot's bit and its value, and returns the slot to the free pool. Every operation is a fixed-length read-modify-write. The block accepts nothing new until the write of the previous operation is done. A response is a single-cycle pulse that carries hit, full, slot and value.

Top module: `keyed_slot_cam`

## Requirements
- R1: After reset `op_ready` is 1, `rsp_valid` is 0, every slot is free and every key misses.
- R2: Operation codes on `op_code` are 2'b01 insert, 2'b10 delete and 2'b11 query. An operation is accepted on a clock edge where `op_valid` and `op_ready` are both 1.
- R3: For an accepted insert, delete or query, `op_ready` is 0 in the two cycles after the accepting edge. In the third cycle `rsp_valid` is 1 for exactly one cycle, and `op_ready` is 1 again.
- R4: An insert with a free slot takes the lowest-numbered free slot and responds with hit=1, full=0, that slot number and the inserted value.
- R5: A query of a stored key responds with hit=1, the lowest-numbered slot holding the key, and that slot's value.
- R6: A query or delete of a key that no slot holds responds with hit=0, full=0, slot 0 and value 0, and changes no state.
- R7: A delete of a stored key frees the lowest-numbered slot holding it and responds with hit=1, that slot and its old value. The freed slot is the next one handed out.
- R8: An insert when no slot is free responds with full=1, hit=0, slot 0 and value 0, and changes no stored entry.
- R9: The same key may be inserted into several slots. Query and delete act on its lowest-numbered slot, and the remaining copies stay visible.
- R10: An operation with code 2'b00 is ignored. It produces no response and leaves `op_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 01 insert, 10 delete, 11 query, 00 none |
| op_key | input | KEY_W (8) | Lookup key, used as the match-vector address |
| op_value | input | VAL_W (16) | Value stored by an insert |
| op_ready | output | 1 | Block can accept an operation |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Insert succeeded, or query/delete found the key |
| rsp_full | output | 1 | Insert refused because no slot is free |
| rsp_slot | output | SLOT_W (5) | Slot used or found |
| rsp_value | output | VAL_W (16) | Inserted, found or deleted value; 0 on a miss |

## Verification
The assertions assume that requests follow the valid/ready rule: an operation counts only on an edge where `op_ready` is 1. They also assume that every response is one of the defined outcomes, so a refusal for lack of space can only come while the free bitmap is empty. The bench drives one operation at a time. It raises `op_valid` only while `op_ready` is high and drops it right after the accepting edge, so no request is ever held across a busy window. Its reference model tracks slot ownership with plain arrays and predicts every response cycle and field.

// File: rtl/cam_pkg.sv
// Shared types for the key-addressed CAM.
// Assumes: two-bit operation encoding, as fixed by the brief.
package cam_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_INSERT = 2'b01,
        OP_DELETE = 2'b10,
        OP_QUERY  = 2'b11
    } cam_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_READ = 2'b01,
        ST_EXEC = 2'b10
    } cam_state_t;
endpackage

// File: rtl/cam_prio_enc.sv
// Lowest-index priority encoder.
// Returns the index of the lowest set bit of vec_i and whether any bit is set.
// Assumes: WIDTH >= 2; the index is 0 when no bit is set.
module cam_prio_enc #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/cam_match_mem.sv
// Key-addressed match-vector memory: one word per key, one bit per slot.
// Registered read, single write port. Resets to all-zero vectors (no key stored).
// Assumes: a write and a read of the same word never fall on the same edge.
module cam_match_mem #(
    parameter int KEY_W = 8,
    parameter int SLOTS = 32,
    localparam int WORDS = 1 << KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [KEY_W-1:0] rd_key,
    output logic [SLOTS-1:0] rd_vec,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [SLOTS-1:0] wr_vec
);
    logic [SLOTS-1:0] mem_q [WORDS];

    // Storage update: clear on reset, otherwise write the new vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (wr_en) begin
            mem_q[wr_key] <= wr_vec;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_vec <= '0;
        else if (rd_en) rd_vec <= mem_q[rd_key];
    end
endmodule

// File: rtl/cam_free_map.sv
// Free-slot bitmap: 1 = available, 0 = in use. Resets to all available.
// Assumes: alloc and release never target the same slot on one edge.
module cam_free_map #(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic              release_en,
    input  logic [SLOT_W-1:0] release_slot,
    output logic [SLOTS-1:0]  free_vec
);
    // Clear a bit on allocation, set it on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_vec <= '1;
        end else begin
            if (alloc_en)   free_vec[alloc_slot]   <= 1'b0;
            if (release_en) free_vec[release_slot] <= 1'b1;
        end
    end
endmodule

// File: rtl/cam_value_store.sv
// Slot-indexed value store with a combinational read and one write port.
// Assumes: reading a slot in the cycle it is written returns the old value.
module cam_value_store #(
    parameter int SLOTS = 32,
    parameter int VAL_W = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [VAL_W-1:0]  rd_value,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VAL_W-1:0]  wr_value
);
    logic [VAL_W-1:0] val_q [SLOTS];

    // Slot write, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) val_q[s] <= '0;
        end else if (wr_en) begin
            val_q[wr_slot] <= wr_value;
        end
    end

    // Asynchronous read of the addressed slot.
    assign rd_value = val_q[rd_slot];
endmodule

// File: rtl/keyed_slot_cam.sv
// Exact-match CAM built from a key-addressed match-vector memory, a slot-indexed
// value store and a free-slot bitmap with lowest-index allocation.
// Each operation runs IDLE -> READ -> EXEC; the response leaves on the edge that
// ends EXEC, and the block is ready again in that same cycle.
// Assumes: the requester keeps op_valid meaningful only while op_ready is 1.
module keyed_slot_cam
    import cam_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int SLOTS = 32,
    parameter int VAL_W = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [KEY_W-1:0]  op_key,
    input  logic [VAL_W-1:0]  op_value,
    output logic              op_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_full,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [VAL_W-1:0]  rsp_value
);
    cam_state_t       state_q;
    cam_op_t          op_q;
    logic [KEY_W-1:0] key_q;
    logic [VAL_W-1:0] val_q;

    logic [SLOTS-1:0]  match_vec;
    logic [SLOTS-1:0]  free_vec;
    logic [SLOT_W-1:0] hit_slot, free_slot;
    logic              hit_any, free_any;
    logic [VAL_W-1:0]  stored_val;

    logic              mem_wr_en;
    logic [SLOTS-1:0]  mem_wr_vec;
    logic              vs_wr_en;
    logic [SLOT_W-1:0] vs_wr_slot;
    logic [VAL_W-1:0]  vs_wr_val;
    logic              alloc_en, release_en;
    logic              nx_hit, nx_full;
    logic [SLOT_W-1:0] nx_slot;
    logic [VAL_W-1:0]  nx_value;

    wire accept = op_valid && op_ready && (op_code != OP_NONE);
    wire in_exec = (state_q == ST_EXEC);

    assign op_ready = (state_q == ST_IDLE);

    cam_match_mem #(.KEY_W(KEY_W), .SLOTS(SLOTS)) u_match (
        .clk(clk), .rst_n(rst_n),
        .rd_en(state_q == ST_READ), .rd_key(key_q), .rd_vec(match_vec),
        .wr_en(mem_wr_en), .wr_key(key_q), .wr_vec(mem_wr_vec)
    );

    cam_prio_enc #(.WIDTH(SLOTS)) u_hit_enc (
        .vec_i(match_vec), .idx_o(hit_slot), .any_o(hit_any)
    );

    cam_prio_enc #(.WIDTH(SLOTS)) u_free_enc (
        .vec_i(free_vec), .idx_o(free_slot), .any_o(free_any)
    );

    cam_free_map #(.SLOTS(SLOTS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_slot(free_slot),
        .release_en(release_en), .release_slot(hit_slot),
        .free_vec(free_vec)
    );

    cam_value_store #(.SLOTS(SLOTS), .VAL_W(VAL_W)) u_vals (
        .clk(clk), .rst_n(rst_n),
        .rd_slot(hit_slot), .rd_value(stored_val),
        .wr_en(vs_wr_en), .wr_slot(vs_wr_slot), .wr_value(vs_wr_val)
    );

    // Sequencer: capture a request, read its vector, then execute and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            key_q   <= '0;
            val_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_READ;
                    op_q    <= cam_op_t'(op_code);
                    key_q   <= op_key;
                    val_q   <= op_value;
                end
                ST_READ: state_q <= ST_EXEC;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Execute stage: writes and response fields for the captured operation.
    always_comb begin
        mem_wr_en  = 1'b0;
        mem_wr_vec = match_vec;
        vs_wr_en   = 1'b0;
        vs_wr_slot = free_slot;
        vs_wr_val  = val_q;
        alloc_en   = 1'b0;
        release_en = 1'b0;
        nx_hit     = 1'b0;
        nx_full    = 1'b0;
        nx_slot    = '0;
        nx_value   = '0;
        if (in_exec) begin
            case (op_q)
                OP_INSERT: begin
                    if (free_any) begin
                        mem_wr_en  = 1'b1;
                        mem_wr_vec = match_vec | (SLOTS'(1) << free_slot);
                        vs_wr_en   = 1'b1;
                        alloc_en   = 1'b1;
                        nx_hit     = 1'b1;
                        nx_slot    = free_slot;
                        nx_value   = val_q;
                    end else begin
                        nx_full = 1'b1;
                    end
                end
                OP_DELETE: begin
                    if (hit_any) begin
                        mem_wr_en  = 1'b1;
                        mem_wr_vec = match_vec & ~(SLOTS'(1) << hit_slot);
                        vs_wr_en   = 1'b1;
                        vs_wr_slot = hit_slot;
                        vs_wr_val  = '0;
                        release_en = 1'b1;
                        nx_hit     = 1'b1;
                        nx_slot    = hit_slot;
                        nx_value   = stored_val;
                    end
                end
                OP_QUERY: begin
                    if (hit_any) begin
                        nx_hit   = 1'b1;
                        nx_slot  = hit_slot;
                        nx_value = stored_val;
                    end
                end
                default: ;
            endcase
        end
    end

    // Response register: one-cycle pulse after the execute stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_full  <= 1'b0;
            rsp_slot  <= '0;
            rsp_value <= '0;
        end else begin
            rsp_valid <= in_exec;
            rsp_hit   <= nx_hit;
            rsp_full  <= nx_full;
            rsp_slot  <= nx_slot;
            rsp_value <= nx_value;
        end
    end
endmodule

// File: rtl/keyed_slot_cam_checker.sv
// Protocol and outcome checks for keyed_slot_cam, attached by bind.
// Assumes: free_vec is the block's internal free-slot bitmap.
module keyed_slot_cam_checker #(
    parameter int SLOTS = 32,
    parameter int SLOT_W = 5,
    parameter int VAL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_code,
    input logic              op_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_full,
    input logic [SLOT_W-1:0] rsp_slot,
    input logic [VAL_W-1:0]  rsp_value,
    input logic [SLOTS-1:0]  free_vec
);
    wire acc = op_valid && op_ready && (op_code != 2'b00);
    wire nop = op_valid && op_ready && (op_code == 2'b00);

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !op_ready); // R3
    AST_RSP_THIRD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##3 rsp_valid); // R3
    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3
    AST_READY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> op_ready); // R3
    AST_FULL_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_full) |-> (free_vec == '0)); // R8
    AST_FULL_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_full) |-> (!rsp_hit && rsp_value == '0)); // R8
    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_slot == '0 && rsp_value == '0)); // R6
    AST_NOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        nop |=> (op_ready && !rsp_valid)); // R10
endmodule

bind keyed_slot_cam keyed_slot_cam_checker #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .VAL_W(VAL_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_ready(op_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_full(rsp_full), .rsp_slot(rsp_slot), .rsp_value(rsp_value),
    .free_vec(free_vec)
);

// File: tb/keyed_slot_cam_bench.sv
// Self-checking bench: a behavioural slot-ownership model predicts every
// response, and ready/valid are compared on each cycle of every operation.
module keyed_slot_cam_bench;
    localparam int KEY_W = 8;
    localparam int SLOTS = 32;
    localparam int VAL_W = 16;
    localparam int SLOT_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [1:0]        op_code = 2'b00;
    logic [KEY_W-1:0]  op_key = '0;
    logic [VAL_W-1:0]  op_value = '0;
    logic              op_ready, rsp_valid, rsp_hit, rsp_full;
    logic [SLOT_W-1:0] rsp_slot;
    logic [VAL_W-1:0]  rsp_value;

    int vectors = 0;
    int errors = 0;

    // Reference model state
    bit m_used [SLOTS];
    int m_key  [SLOTS];
    int m_val  [SLOTS];

    always #2 clk = ~clk;

    keyed_slot_cam #(.KEY_W(KEY_W), .SLOTS(SLOTS), .VAL_W(VAL_W)) u_keyed_slot_cam (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_key(op_key), .op_value(op_value), .op_ready(op_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_full(rsp_full),
        .rsp_slot(rsp_slot), .rsp_value(rsp_value)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one operation, predict it with the model, compare cycle by cycle.
    task automatic run_op(input string req, input int code, input int key, input int val);
        int e_hit = 0, e_full = 0, e_slot = 0, e_val = 0;
        int found = -1, freeslot = -1;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (m_used[s] && m_key[s] == key) found = s;
            if (!m_used[s]) freeslot = s;
        end
        case (code)
            1: if (freeslot >= 0) begin
                   e_hit = 1; e_slot = freeslot; e_val = val;
                   m_used[freeslot] = 1; m_key[freeslot] = key; m_val[freeslot] = val;
               end else e_full = 1;
            2: if (found >= 0) begin
                   e_hit = 1; e_slot = found; e_val = m_val[found];
                   m_used[found] = 0; m_val[found] = 0;
               end
            3: if (found >= 0) begin
                   e_hit = 1; e_slot = found; e_val = m_val[found];
               end
            default: ;
        endcase
        @(negedge clk);
        check(req, "ready before op", int'(op_ready), 1);
        op_valid = 1'b1; op_code = 2'(code); op_key = KEY_W'(key); op_value = VAL_W'(val);
        @(posedge clk); #1;
        op_valid = 1'b0; op_code = 2'b00;
        if (code == 0) begin
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                check(req, "nop ready", int'(op_ready), 1);
                check(req, "nop rsp_valid", int'(rsp_valid), 0);
            end
            return;
        end
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            check(req, "busy ready", int'(op_ready), 0);
            check(req, "early rsp_valid", int'(rsp_valid), 0);
        end
        @(negedge clk);
        check(req, "rsp_valid", int'(rsp_valid), 1);
        check(req, "ready with rsp", int'(op_ready), 1);
        check(req, "rsp_hit", int'(rsp_hit), e_hit);
        check(req, "rsp_full", int'(rsp_full), e_full);
        check(req, "rsp_slot", int'(rsp_slot), e_slot);
        check(req, "rsp_value", int'(rsp_value), e_val);
        @(negedge clk);
        check(req, "rsp pulse ends", int'(rsp_valid), 0);
    endtask

    initial begin
        for (int s = 0; s < SLOTS; s++) begin
            m_used[s] = 0; m_key[s] = 0; m_val[s] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset ready", int'(op_ready), 1);
        check("R1", "reset rsp_valid", int'(rsp_valid), 0);
        run_op("R1", 3, 8'h05, 0);                      // empty table misses
        run_op("R6", 2, 8'h05, 0);                      // delete miss
        run_op("R4", 1, 8'h10, 16'hA001);               // slot 0
        run_op("R4", 1, 8'h22, 16'hA002);               // slot 1
        run_op("R2", 3, 8'h10, 0);                      // query hit
        run_op("R9", 1, 8'h10, 16'hB0B0);               // duplicate, slot 2
        run_op("R5", 3, 8'h22, 0);
        run_op("R10", 0, 8'h22, 16'hFFFF);              // ignored
        run_op("R10", 3, 8'h22, 0);                     // unchanged after nop
        run_op("R6", 3, 8'h11, 0);                      // neighbour key misses
        for (int k = 0; k < 29; k++)
            run_op("R4", 1, 8'h40 + k, 16'h1000 + k);   // fill remaining slots
        run_op("R8", 1, 8'hEE, 16'hDEAD);               // full
        run_op("R8", 3, 8'hEE, 0);                      // refused key absent
        run_op("R8", 3, 8'h5C, 0);                      // last stored entry intact
        run_op("R9", 2, 8'h10, 0);                      // removes slot 0
        run_op("R9", 3, 8'h10, 0);                      // copy in slot 2 visible
        run_op("R7", 1, 8'h77, 16'h7777);               // reuses slot 0
        run_op("R7", 2, 8'h40, 0);                      // frees slot 3
        run_op("R7", 3, 8'h40, 0);                      // now misses
        run_op("R7", 1, 8'h41, 16'h4141);               // takes slot 3
        run_op("R5", 3, 8'h41, 0);                      // lowest copy of 0x41
        run_op("R9", 2, 8'h10, 0);
        run_op("R6", 3, 8'h10, 0);                      // all copies gone
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule